// File: doc/BRIEF.md
# Frame-Time Transfer Scheduling Gate

This block decides, within one host-side bus frame, which transfer class may start its next transaction. A frame-time counter is loaded with the frame length at every start of frame and counts down on bit-time ticks. Early in the frame, control and bulk traffic is preferred. Once the remaining time falls to a programmable periodic-start point, periodic (interrupt) traffic takes precedence until the next start of frame. A transaction already under way is never cut short. It always finishes before the next grant.

A second programmable threshold limits low-speed packets. A low-speed start is allowed only while the remaining frame time is at least that threshold. A low-speed request that is refused stays pending and receives no grant until the next frame begins. Both thresholds sit behind a simple write/read register port.

The arbiter state machine has four states. `ST_IDLE` waits for an eligible request while no transaction is busy. `ST_GNT_CB` and `ST_GNT_PER` each last one cycle and drive the control/bulk or periodic grant. `ST_WAIT` holds until the transaction-done pulse. The transitions are: IDLE to GNT_CB or GNT_PER, chosen by the current priority phase; either grant state to WAIT, unconditionally; WAIT to IDLE when done is seen.

Top module: `frame_sched_gate`

## Requirements
- R1: After reset, the periodic-start field reads 0, the low-speed threshold reads 0x628, and both grants are low.
- R2: `reg_sel`=0 selects the periodic-start field, held in data bits 13:0. `reg_sel`=1 selects the low-speed threshold, held in bits 11:0. Upper data bits always read as zero, and writes to them are ignored.
- R3: The remaining-time counter loads `frame_interval` on the clock edge where `sof` is high. Otherwise it decrements on each `bit_tick` edge, and it holds at zero without wrapping.
- R4: `ls_ok` is high exactly when the remaining time is greater than or equal to the low-speed threshold.
- R5: While the remaining time is above the periodic-start value, a control/bulk request wins over a simultaneous periodic request. From the cycle after the remaining time reaches the periodic-start value, the periodic request wins.
- R6: No grant is issued while `xact_busy` is high or while a granted transaction has not yet signalled `xact_done`. The arbiter returns to idle one edge after done, and a waiting request is granted on the following edge.
- R7: At most one grant is high in any cycle, and each grant is a single-cycle pulse.
- R8: A low-speed request (`*_ls`=1) that is presented while `ls_ok` is low is refused. No low-speed request is granted again until the next `sof`, even if `ls_ok` rises in the meantime. Full-speed requests are unaffected.
- R9: `sof` returns priority to control/bulk until the periodic-start point is reached again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: periodic-start field, 1: low-speed threshold |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| frame_interval | input | 14 | Frame length in bit times |
| sof | input | 1 | Start-of-frame pulse |
| bit_tick | input | 1 | One pulse per bit time |
| cb_req | input | 1 | Control/bulk request |
| cb_ls | input | 1 | Control/bulk request is low-speed |
| cb_gnt | output | 1 | Control/bulk grant pulse |
| per_req | input | 1 | Periodic request |
| per_ls | input | 1 | Periodic request is low-speed |
| per_gnt | output | 1 | Periodic grant pulse |
| ls_ok | output | 1 | Low-speed start currently allowed |
| xact_busy | input | 1 | A transaction is in progress |
| xact_done | input | 1 | Granted transaction finished |

## Verification
The bench stops the remaining time at 41 and then at 40 with a periodic-start value of 40. A design that compares one off would grant the wrong class at one of these points. It also counts far past zero, where a wrapping counter would raise `ls_ok` again. It raises a periodic request while a control/bulk transaction is still busy across the threshold; a design that pre-empts would pulse the periodic grant before done. Finally, it rewrites the low-speed threshold after a refusal. A design that forgets the refusal would grant the low-speed request in the same frame.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam int PS_W      = 14;
    localparam int LST_W     = 12;
    localparam int DATA_W    = 32;
    localparam logic [LST_W-1:0] LST_RESET = 12'h628;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GNT_CB,
        ST_GNT_PER,
        ST_WAIT
    } arb_state_t;
endpackage

// File: rtl/fsg_regs.sv
module fsg_regs
    import fsg_pkg::*;
#(
    parameter int P_PS_W   = PS_W,
    parameter int P_LST_W  = LST_W,
    parameter int P_DATA_W = DATA_W,
    parameter logic [P_LST_W-1:0] P_LST_RESET = LST_RESET
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_sel,
    input  logic [P_DATA_W-1:0] reg_wdata,
    output logic [P_DATA_W-1:0] reg_rdata,
    output logic [P_PS_W-1:0]   ps_thr,
    output logic [P_LST_W-1:0]  ls_thr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_thr <= '0;
            ls_thr <= P_LST_RESET;
        end else if (reg_wr) begin
            if (reg_sel) ls_thr <= reg_wdata[P_LST_W-1:0];
            else         ps_thr <= reg_wdata[P_PS_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) reg_rdata[P_LST_W-1:0] = ls_thr;
        else         reg_rdata[P_PS_W-1:0]  = ps_thr;
    end

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel) |=> (ps_thr == $past(reg_wdata[P_PS_W-1:0]))); // R2
endmodule

// File: rtl/fsg_frame_timer.sv
module fsg_frame_timer
    import fsg_pkg::*;
#(
    parameter int P_PS_W  = PS_W,
    parameter int P_LST_W = LST_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof,
    input  logic               bit_tick,
    input  logic [P_PS_W-1:0]  frame_interval,
    input  logic [P_PS_W-1:0]  ps_thr,
    input  logic [P_LST_W-1:0] ls_thr,
    output logic               per_phase,
    output logic               ls_ok
);
    localparam int PAD_W = P_PS_W - P_LST_W;

    logic [P_PS_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q     <= '0;
            per_phase <= 1'b0;
        end else begin
            if (sof)                        rem_q <= frame_interval;
            else if (bit_tick && rem_q != 0) rem_q <= rem_q - 1'b1;
            per_phase <= sof ? 1'b0 : (per_phase | (rem_q <= ps_thr));
        end
    end

    assign ls_ok = (rem_q >= {{PAD_W{1'b0}}, ls_thr});

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && rem_q == 0) |=> (rem_q == 0)); // R3
    AST_PHASE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (per_phase && !sof) |=> per_phase); // R5
endmodule

// File: rtl/fsg_arbiter.sv
module fsg_arbiter
    import fsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic per_phase,
    input  logic ls_ok,
    input  logic cb_req,
    input  logic cb_ls,
    input  logic per_req,
    input  logic per_ls,
    input  logic xact_busy,
    input  logic xact_done,
    output logic cb_gnt,
    output logic per_gnt
);
    arb_state_t state_q, state_d;
    logic       ls_closed_q;
    logic       cb_ok, per_ok, ls_refuse;

    always_comb begin
        cb_ok     = cb_req  && !(cb_ls  && (ls_closed_q || !ls_ok));
        per_ok    = per_req && !(per_ls && (ls_closed_q || !ls_ok));
        ls_refuse = (state_q == ST_IDLE) && !ls_ok &&
                    ((cb_req && cb_ls) || (per_req && per_ls));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!xact_busy) begin
                    if (per_phase) begin
                        if (per_ok)     state_d = ST_GNT_PER;
                        else if (cb_ok) state_d = ST_GNT_CB;
                    end else begin
                        if (cb_ok)       state_d = ST_GNT_CB;
                        else if (per_ok) state_d = ST_GNT_PER;
                    end
                end
            end
            ST_GNT_CB:  state_d = ST_WAIT;
            ST_GNT_PER: state_d = ST_WAIT;
            ST_WAIT:    if (xact_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            ls_closed_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            ls_closed_q <= sof ? 1'b0 : (ls_closed_q | ls_refuse);
        end
    end

    always_comb begin
        cb_gnt  = (state_q == ST_GNT_CB);
        per_gnt = (state_q == ST_GNT_PER);
    end

    AST_ONE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cb_gnt && per_gnt)); // R7
    AST_GNT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_gnt || per_gnt) |=> !(cb_gnt || per_gnt)); // R7
    AST_NO_GNT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cb_gnt || per_gnt) |-> !$past(xact_busy)); // R6
    AST_LS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cb_gnt) |-> !$past(cb_ls && ls_closed_q)); // R8
endmodule

// File: rtl/frame_sched_gate.sv
module frame_sched_gate
    import fsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [PS_W-1:0]   frame_interval,
    input  logic              sof,
    input  logic              bit_tick,
    input  logic              cb_req,
    input  logic              cb_ls,
    output logic              cb_gnt,
    input  logic              per_req,
    input  logic              per_ls,
    output logic              per_gnt,
    output logic              ls_ok,
    input  logic              xact_busy,
    input  logic              xact_done
);
    logic [PS_W-1:0]  ps_thr;
    logic [LST_W-1:0] ls_thr;
    logic             per_phase;

    fsg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ps_thr    (ps_thr),
        .ls_thr    (ls_thr)
    );

    fsg_frame_timer u_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .sof            (sof),
        .bit_tick       (bit_tick),
        .frame_interval (frame_interval),
        .ps_thr         (ps_thr),
        .ls_thr         (ls_thr),
        .per_phase      (per_phase),
        .ls_ok          (ls_ok)
    );

    fsg_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof       (sof),
        .per_phase (per_phase),
        .ls_ok     (ls_ok),
        .cb_req    (cb_req),
        .cb_ls     (cb_ls),
        .per_req   (per_req),
        .per_ls    (per_ls),
        .xact_busy (xact_busy),
        .xact_done (xact_done),
        .cb_gnt    (cb_gnt),
        .per_gnt   (per_gnt)
    );
endmodule

// File: tb/frame_sched_gate_test.sv
module frame_sched_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [13:0] frame_interval = 14'd100;
    logic        sof = 1'b0, bit_tick = 1'b0;
    logic        cb_req = 1'b0, cb_ls = 1'b0, cb_gnt;
    logic        per_req = 1'b0, per_ls = 1'b0, per_gnt;
    logic        ls_ok, xact_busy = 1'b0, xact_done = 1'b0;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    frame_sched_gate uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [31:0] exp, input string tag);
        reg_sel = sel;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic do_sof();
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        bit_tick = 1'b1;
        repeat (n) @(negedge clk);
        bit_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic serve(input logic c, input logic p, input logic exp_c,
                         input logic exp_p, input string tag);
        cb_req = c; per_req = p;
        @(negedge clk);
        check({tag, " cb_gnt"}, cb_gnt, exp_c);
        check({tag, " per_gnt"}, per_gnt, exp_p);
        cb_req = 1'b0; per_req = 1'b0;
        if (cb_gnt || per_gnt) begin
            xact_busy = 1'b1;
            @(negedge clk);
            xact_busy = 1'b0; xact_done = 1'b1;
            @(negedge clk);
            xact_done = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rd(1'b0, 32'h0, "R1 ps reset");
        rd(1'b1, 32'h628, "R1 lst reset");
        check("R1 cb_gnt reset", cb_gnt, 1'b0);
        check("R1 per_gnt reset", per_gnt, 1'b0);
    endtask

    task automatic t_regs();
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, 32'h3FFF, "R2 ps reserved");
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, 32'hFFF, "R2 lst reserved");
        wr(1'b0, 32'hABCD_0028);
        rd(1'b0, 32'h0028, "R2 ps write");
        wr(1'b1, 32'h0000_0032);
        rd(1'b1, 32'h0032, "R2 lst write");
    endtask

    task automatic t_counter();
        frame_interval = 14'd100;
        do_sof();
        check("R3 R4 load ls_ok", ls_ok, 1'b1);
        ticks(50);
        check("R3 R4 rem=50 ls_ok", ls_ok, 1'b1);
        ticks(1);
        check("R3 R4 rem=49 ls_ok", ls_ok, 1'b0);
        ticks(200);
        check("R3 no wrap ls_ok", ls_ok, 1'b0);
    endtask

    task automatic t_priority();
        do_sof();
        serve(1'b1, 1'b1, 1'b1, 1'b0, "R5 early frame");
        ticks(59);
        serve(1'b1, 1'b1, 1'b1, 1'b0, "R5 rem=41");
        ticks(1);
        serve(1'b1, 1'b1, 1'b0, 1'b1, "R5 rem=40");
        serve(1'b1, 1'b0, 1'b1, 1'b0, "R5 cb alone late");
    endtask

    task automatic t_inflight();
        do_sof();
        cb_req = 1'b1;
        @(negedge clk);
        check("R6 cb granted", cb_gnt, 1'b1);
        cb_req = 1'b0; xact_busy = 1'b1;
        ticks(70);
        per_req = 1'b1;
        @(negedge clk);
        check("R6 busy no per_gnt", per_gnt, 1'b0);
        @(negedge clk);
        check("R6 busy no per_gnt 2", per_gnt, 1'b0);
        xact_busy = 1'b0; xact_done = 1'b1;
        @(negedge clk);
        xact_done = 1'b0;
        check("R6 idle cycle", per_gnt, 1'b0);
        @(negedge clk);
        check("R6 per after done", per_gnt, 1'b1);
        check("R7 exclusive", cb_gnt, 1'b0);
        per_req = 1'b0;
        @(negedge clk);
        check("R7 pulse", per_gnt, 1'b0);
        xact_done = 1'b1;
        @(negedge clk);
        xact_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_sof_return();
        do_sof();
        serve(1'b1, 1'b1, 1'b1, 1'b0, "R9 after sof");
    endtask

    task automatic t_lowspeed();
        wr(1'b1, 32'd50);
        do_sof();
        ticks(51);
        check("R4 rem=49 below", ls_ok, 1'b0);
        cb_req = 1'b1; cb_ls = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 refused", cb_gnt, 1'b0);
        end
        cb_req = 1'b0;
        wr(1'b1, 32'd0);
        @(negedge clk);
        check("R4 lst=0", ls_ok, 1'b1);
        cb_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 held pending", cb_gnt, 1'b0);
        end
        cb_req = 1'b0; cb_ls = 1'b0;
        serve(1'b1, 1'b0, 1'b1, 1'b0, "R8 full-speed ok");
        do_sof();
        cb_ls = 1'b1;
        serve(1'b1, 1'b0, 1'b1, 1'b0, "R8 next frame");
        cb_ls = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_counter();
        t_priority();
        t_inflight();
        t_sof_return();
        t_lowspeed();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule